// File: doc/BRIEF.md
# Round-Robin Multithread Lock Arbiter

This block is one global hardware lock shared by a set of hardware threads. A typical use is guarding updates to a shared translation table. Each thread raises a one-cycle lock request or unlock request. The arbiter keeps a two-bit lock state for every thread and a single "held" bit. It answers every request it processes with per-thread pulses and levels:

- a retire pulse, which lets the thread's program counter advance;
- a halt level, which stalls the thread;
- a wake pulse, which restarts a stalled thread;
- an error pulse for a double lock;
- an error pulse for an unlock by a thread that does not own the lock.

On a valid release the lock is not simply dropped. The arbiter searches for waiting threads, starting at the thread just after the releaser and wrapping around. The first waiter it finds is moved to a reserved "queued" state, and the held bit stays set. That waiter is woken. It then re-executes its lock request and becomes owner without competing again.

Requests that arrive in the same cycle are served one per cycle, lowest thread id first. Requests not yet served stay pending inside the block.

Top module: `rr_lock_arbiter`

## Requirements
- R1: Thread i's state sits in `state_o[2*i+1:2*i]`, encoded as free = 0, waiting = 1, owner = 2, queued = 3. Reset drives every state to free and clears `held_o`, the halt levels and all pulses.
- R2: A lock request processed while `held_o` is 0 sets `held_o`, makes the thread owner and pulses its retire bit one cycle after the request.
- R3: A lock request processed while `held_o` is 1, from a queued thread, makes it owner, keeps `held_o` set and pulses its retire bit.
- R4: A lock request processed while `held_o` is 1, from the owner itself, pulses retire and `err_double_o`, sets the thread's halt, and leaves it owner.
- R5: A lock request processed while `held_o` is 1, from a free or waiting thread, makes it waiting and sets its halt, with no retire pulse.
- R6: An unlock from a thread that is not owner changes no state and no held bit, and pulses its `err_unlock_o` bit.
- R7: A valid unlock makes the releaser free. If no thread is waiting, `held_o` clears.
- R8: On a valid unlock, the first waiting thread found at ids releaser+1, releaser+2, ... modulo the thread count becomes queued. `held_o` stays 1, that thread gets a one-cycle wake pulse and its halt clears in the same cycle.
- R9: Of all pending requests, one is processed per cycle: the lowest thread id first, and a thread's lock before its unlock. The others remain pending; none is lost.
- R10: At most one thread is owner or queued at any time, and `held_o` is 1 exactly when such a thread exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_req | input | NTHR | One-cycle lock request per thread |
| unlock_req | input | NTHR | One-cycle unlock request per thread |
| state_o | output | 2*NTHR | Packed per-thread lock state |
| held_o | output | 1 | Global lock bit |
| retire_o | output | NTHR | Retire pulse per thread |
| halt_o | output | NTHR | Stall level per thread |
| wake_o | output | NTHR | Wake pulse per thread |
| err_double_o | output | NTHR | Double-lock error pulse |
| err_unlock_o | output | NTHR | Unlock-without-ownership error pulse |

## Verification
The bench builds the block with the default of four threads. With four threads, a release can find its waiter on either side of the releaser, so the wrap-around search is tested, and a burst of four simultaneous requests exercises the full pending queue. Random request vectors, limited to threads that are not stalled, mix contention, handoffs, double locks and stray unlocks. A reset every few dozen cycles keeps hung owners from freezing the run.

// File: rtl/rrlk_pkg.sv
package rrlk_pkg;
  typedef enum logic [1:0] {
    TS_FREE   = 2'd0,
    TS_WAIT   = 2'd1,
    TS_OWN    = 2'd2,
    TS_QUEUED = 2'd3
  } tstate_e;
endpackage

// File: rtl/rrlk_first_pick.sv
// Fixed-priority pick: lowest set index wins.
module rrlk_first_pick #(
  parameter int NTHR = 4
) (
  input  logic [NTHR-1:0] req,
  output logic [NTHR-1:0] grant,
  output logic            any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < NTHR; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rrlk_rr_search.sv
// Finds the first waiter after the releaser, wrapping modulo NTHR.
module rrlk_rr_search #(
  parameter int NTHR = 4,
  localparam int IW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [NTHR-1:0] waiters,
  input  logic [IW-1:0]   from_id,
  output logic [NTHR-1:0] pick,
  output logic            found
);
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int off = 1; off < NTHR; off++) begin
      int k;
      k = (int'(from_id) + off) % NTHR;
      if (waiters[k] && !found) begin
        pick[k] = 1'b1;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_lock_arbiter.sv
module rr_lock_arbiter #(
  parameter int NTHR = 4,
  localparam int IW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTHR-1:0]   lock_req,
  input  logic [NTHR-1:0]   unlock_req,
  output logic [2*NTHR-1:0] state_o,
  output logic              held_o,
  output logic [NTHR-1:0]   retire_o,
  output logic [NTHR-1:0]   halt_o,
  output logic [NTHR-1:0]   wake_o,
  output logic [NTHR-1:0]   err_double_o,
  output logic [NTHR-1:0]   err_unlock_o
);
  import rrlk_pkg::*;

  tstate_e         st_q [NTHR];
  tstate_e         st_d [NTHR];
  logic [NTHR-1:0] pend_lk_q, pend_ul_q, pend_lk_d, pend_ul_d;
  logic [NTHR-1:0] req_lk, req_ul, grant, waiters, wpick;
  logic [NTHR-1:0] halt_q, halt_d, retire_d, wake_d, edbl_d, eunl_d;
  logic [NTHR-1:0] retire_q, wake_q, edbl_q, eunl_q;
  logic            held_q, held_d, any, found, do_lock, do_unl;
  logic [IW-1:0]   sel_id;

  assign req_lk = pend_lk_q | lock_req;
  assign req_ul = pend_ul_q | unlock_req;

  rrlk_first_pick #(.NTHR(NTHR)) u_pick (
    .req   (req_lk | req_ul),
    .grant (grant),
    .any   (any)
  );

  always_comb begin
    sel_id = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (grant[i]) sel_id = IW'(i);
    end
  end

  generate
    for (genvar g = 0; g < NTHR; g++) begin : g_wait
      assign waiters[g] = (st_q[g] == TS_WAIT);
      assign state_o[2*g +: 2] = st_q[g];
    end
  endgenerate

  rrlk_rr_search #(.NTHR(NTHR)) u_search (
    .waiters (waiters),
    .from_id (sel_id),
    .pick    (wpick),
    .found   (found)
  );

  // Next-state logic
  always_comb begin
    do_lock   = any && req_lk[sel_id];
    do_unl    = any && !req_lk[sel_id] && req_ul[sel_id];
    pend_lk_d = req_lk & ~(do_lock ? grant : '0);
    pend_ul_d = req_ul & ~(do_unl  ? grant : '0);
    st_d      = st_q;
    held_d    = held_q;
    halt_d    = halt_q;
    retire_d  = '0;
    wake_d    = '0;
    edbl_d    = '0;
    eunl_d    = '0;
    if (do_lock) begin
      if (!held_q) begin
        st_d[sel_id]     = TS_OWN;
        held_d           = 1'b1;
        retire_d[sel_id] = 1'b1;
      end else begin
        case (st_q[sel_id])
          TS_QUEUED: begin
            st_d[sel_id]     = TS_OWN;
            retire_d[sel_id] = 1'b1;
          end
          TS_OWN: begin
            retire_d[sel_id] = 1'b1;
            edbl_d[sel_id]   = 1'b1;
            halt_d[sel_id]   = 1'b1;
          end
          default: begin
            st_d[sel_id]   = TS_WAIT;
            halt_d[sel_id] = 1'b1;
          end
        endcase
      end
    end else if (do_unl) begin
      if (held_q && st_q[sel_id] == TS_OWN) begin
        st_d[sel_id] = TS_FREE;
        held_d       = found;
        for (int j = 0; j < NTHR; j++) begin
          if (wpick[j]) begin
            st_d[j]   = TS_QUEUED;
            wake_d[j] = 1'b1;
            halt_d[j] = 1'b0;
          end
        end
      end else begin
        eunl_d[sel_id] = 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) st_q[i] <= TS_FREE;
      held_q    <= 1'b0;
      halt_q    <= '0;
      pend_lk_q <= '0;
      pend_ul_q <= '0;
      retire_q  <= '0;
      wake_q    <= '0;
      edbl_q    <= '0;
      eunl_q    <= '0;
    end else begin
      pend_lk_q <= pend_lk_d;
      pend_ul_q <= pend_ul_d;
      retire_q  <= retire_d;
      wake_q    <= wake_d;
      edbl_q    <= edbl_d;
      eunl_q    <= eunl_d;
      if (any) begin
        st_q   <= st_d;
        held_q <= held_d;
        halt_q <= halt_d;
      end
    end
  end

  assign held_o       = held_q;
  assign halt_o       = halt_q;
  assign retire_o     = retire_q;
  assign wake_o       = wake_q;
  assign err_double_o = edbl_q;
  assign err_unlock_o = eunl_q;
endmodule

// File: rtl/rrlk_checker.sv
module rrlk_checker #(
  parameter int NTHR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NTHR-1:0]   lock_req,
  input logic [NTHR-1:0]   unlock_req,
  input logic [2*NTHR-1:0] state_o,
  input logic              held_o,
  input logic [NTHR-1:0]   retire_o,
  input logic [NTHR-1:0]   halt_o,
  input logic [NTHR-1:0]   wake_o,
  input logic [NTHR-1:0]   err_double_o,
  input logic [NTHR-1:0]   err_unlock_o
);
  logic [NTHR-1:0] holder, queued, pulsed;

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      holder[i] = state_o[2*i+1];
      queued[i] = (state_o[2*i +: 2] == 2'd3);
      pulsed[i] = retire_o[i] | wake_o[i] | err_double_o[i] | err_unlock_o[i];
    end
  end

  AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(holder) <= 1); // R10

  AST_HELD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    held_o == (|holder)); // R10

  AST_WAKE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o & ~queued) == '0); // R8

  AST_WAKE_UNHALT: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o & halt_o) == '0); // R8

  AST_WAKE_KEEPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_o) |-> held_o); // R8

  AST_BAD_UNLOCK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_unlock_o) |-> ($stable(state_o) && $stable(held_o))); // R6

  AST_DOUBLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_double_o) |-> ((err_double_o & ~(halt_o & retire_o)) == '0)); // R4

  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulsed)); // R9
endmodule

bind rr_lock_arbiter rrlk_checker #(.NTHR(NTHR)) u_chk (.*);

// File: tb/rr_lock_arbiter_test.sv
`timescale 1ns/1ps
module rr_lock_arbiter_test;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    lock_req, unlock_req;
  logic [2*N-1:0]  state_o;
  logic            held_o;
  logic [N-1:0]    retire_o, halt_o, wake_o, err_double_o, err_unlock_o;

  always #2.5 clk = ~clk;

  rr_lock_arbiter #(.NTHR(N)) uut (.*);

  int n_chk = 0, n_bad = 0;

  // model state
  int          m_st [N];
  logic        m_held;
  logic [N-1:0] m_halt, m_plk, m_pul;
  logic [N-1:0] e_ret, e_wake, e_dbl, e_unl;

  function automatic logic [2*N-1:0] pack_st();
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = m_st[i][1:0];
    return v;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_st[i] = 0;
    m_held = 0; m_halt = '0; m_plk = '0; m_pul = '0;
    e_ret = '0; e_wake = '0; e_dbl = '0; e_unl = '0;
  endtask

  // one processing step per cycle, from the requirements
  task automatic model_step(input logic [N-1:0] lk, input logic [N-1:0] ul);
    int s;
    bool_found: begin end
    m_plk |= lk; m_pul |= ul;
    e_ret = '0; e_wake = '0; e_dbl = '0; e_unl = '0;
    s = -1;
    for (int i = N-1; i >= 0; i--) if (m_plk[i] | m_pul[i]) s = i;
    if (s < 0) return;
    if (m_plk[s]) begin
      m_plk[s] = 1'b0;
      if (!m_held) begin m_st[s] = 2; m_held = 1; e_ret[s] = 1; end
      else if (m_st[s] == 3) begin m_st[s] = 2; e_ret[s] = 1; end
      else if (m_st[s] == 2) begin e_ret[s] = 1; e_dbl[s] = 1; m_halt[s] = 1; end
      else begin m_st[s] = 1; m_halt[s] = 1; end
    end else begin
      m_pul[s] = 1'b0;
      if (m_held && m_st[s] == 2) begin
        int w;
        w = -1;
        m_st[s] = 0;
        for (int off = 1; off < N; off++)
          if (w < 0 && m_st[(s+off)%N] == 1) w = (s+off)%N;
        if (w >= 0) begin
          m_st[w] = 3; e_wake[w] = 1; m_halt[w] = 0;
        end else m_held = 0;
      end else e_unl[s] = 1;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag,  "state",  32'(state_o), 32'(pack_st()));
    chk("R10", "held",  32'(held_o), 32'(m_held));
    chk(tag,  "retire", 32'(retire_o), 32'(e_ret));
    chk(tag,  "halt",   32'(halt_o), 32'(m_halt));
    chk("R8", "wake",   32'(wake_o), 32'(e_wake));
    chk("R4", "errdbl", 32'(err_double_o), 32'(e_dbl));
    chk("R6", "errunl", 32'(err_unlock_o), 32'(e_unl));
  endtask

  // drive at negedge, check at next negedge
  task automatic cyc(input logic [N-1:0] lk, input logic [N-1:0] ul, input string tag);
    lock_req = lk; unlock_req = ul;
    model_step(lk, ul);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lock_req = '0; unlock_req = '0;
    repeat (2) @(negedge clk);
    model_reset();
    compare("R1");
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    do_reset();
    // R9 / R5: all four lock at once
    cyc(4'b1111, 4'b0000, "R2");
    cyc(4'b0000, 4'b0000, "R5");
    cyc(4'b0000, 4'b0000, "R9");
    cyc(4'b0000, 4'b0000, "R5");
    // R8: owner 0 releases, waiter 1 queued
    cyc(4'b0000, 4'b0001, "R8");
    cyc(4'b0010, 4'b0000, "R3");
    // R8 wrap: free 0 contends, then 1 releases -> 2 chosen
    cyc(4'b0001, 4'b0000, "R5");
    cyc(4'b0000, 4'b0010, "R8");
    cyc(4'b0100, 4'b0000, "R3");
    // R6: stray unlock from free thread 1
    cyc(4'b0000, 4'b0010, "R6");
    // 2 releases: waiters 3 and 0 -> 3 first
    cyc(4'b0000, 4'b0100, "R8");
    cyc(4'b1000, 4'b0000, "R3");
    cyc(4'b0000, 4'b1000, "R8"); // wrap to 0
    cyc(4'b0001, 4'b0000, "R3");
    cyc(4'b0000, 4'b0001, "R7");
    // R4: double lock
    cyc(4'b0010, 4'b0000, "R2");
    cyc(4'b0010, 4'b0000, "R4");
    cyc(4'b0000, 4'b0000, "R4");
    do_reset();
    // random phase
    for (int it = 0; it < 3000; it++) begin
      logic [N-1:0] lk, ul;
      if (it % 40 == 39) begin
        do_reset();
      end else begin
        lk = N'($urandom) & N'($urandom) & ~m_halt;
        ul = N'($urandom) & N'($urandom) & ~m_halt & ~lk;
        cyc(lk, ul, "R9");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule